// File: doc/BRIEF.md
# Delayed LMS Weight-Update Engine

This block is the coefficient-adaptation half of a pipelined delayed-LMS adaptive filter. On every cycle where `valid_i` is high it takes one error word and the current contents of the tap delay line (one sample per tap). It scales the error by a power-of-two step size, multiplies the scaled error by each tap's sample, truncates each product to the weight format and adds it to that tap's stored weight. The updated weight vector drives both the filtering datapath and this block's own accumulation feedback.

The step size is 2^-k with k equal to the sample integer bits plus log2 of the tap count. That multiply is only a move of the radix point, so the error word is used unchanged as the multiplicand. Each tap multiplier splits its sample into two-bit digits, selects 0, m, 2m or 3m per digit (the top digit is signed and selects 0, m, -2m or -m), and sums the digit products in a shift-add tree. The tree has a register at its midpoint. The 3m multiple is built once and shared by every tap.

Error generation and the tap delay line are outside this block. Inputs are registered once before the digit stage. That register is counted in the error-path latency. The register in the shift-add tree gives a weight-path delay of one.

Top module: `dlms_wupd`

## Requirements
- R1: While `rst_ni` is low, every weight and every bit of `ovf_o` is zero.
- R2: For one accepted input set, tap t's increment is floor(e*x_t / 2^(XW-XI)), keeping only its low WW bits. Here e is `err_i` and x_t is the tap sample, both read as raw two's-complement integers. The step-size scaling adds no further shift.
- R3: An input set sampled with `valid_i` high on a rising edge changes `weights_o` on the third rising edge, counting that edge as the first. It has no effect on `weights_o` before that edge.
- R4: When `valid_i` is low on an edge, the values on `err_i` and `taps_i` have no effect. The weights and `ovf_o` hold.
- R5: When input sets are accepted on consecutive cycles, each one adds onto the weight left by the one before it. No update is lost.
- R6: The most significant sample digit is signed: x = -2^(XW-1) and x = 2^(XW-1)-1 both give exact products.
- R7: The weight sum wraps modulo 2^WW. `ovf_o[t]` is loaded on every update of tap t. It is set when the true sum of the old weight and the increment falls outside the signed WW-bit range, and cleared otherwise. Between updates it holds.
- R8: Truncation of negative products rounds toward minus infinity. For example, e=-1 and x=1 give an increment of -1.
- R9: Tap t reads its sample from `taps_i[t*XW +: XW]` and presents its weight on `weights_o[t*WW +: WW]`. Its weight depends only on its own sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input set on this edge is accepted |
| err_i | input | WW | Delayed error, two's complement, weight format |
| taps_i | input | NTAPS*XW | Delayed tap samples, tap t in bits t*XW +: XW |
| weights_o | output | NTAPS*WW | Current weights, tap t in bits t*WW +: WW |
| ovf_o | output | NTAPS | Per-tap overflow status of the last update |

## Verification
The two functions that can fall in the same cycle are the wrap and overflow flagging of one update, and the acceptance of the next input set whose increment feeds back onto that wrapped weight. The bench provokes this by sending large error values with mid-range samples on consecutive cycles, so a wrapping update and a fresh accumulation are in flight together. A behavioural reference model predicts every weight and flag from integer arithmetic, with the stated three-edge latency, and is compared on every clock. Idle stretches with noisy inputs and extreme samples are interleaved so that the hold and signed-digit behaviour are judged right after a wrap.

// File: rtl/dlms_wupd_pkg.sv
package dlms_wupd_pkg;
  typedef enum logic [1:0] {
    DIG_ZERO  = 2'd0,
    DIG_ONE   = 2'd1,
    DIG_TWO   = 2'd2,
    DIG_THREE = 2'd3
  } digit_e;
endpackage

// File: rtl/dlms_step_scale.sv
// Step size is a radix move: m equals the error word; 3m is shared by all taps.
module dlms_step_scale #(
  parameter int WW = 12
) (
  input  logic [WW-1:0]        err_i,
  output logic signed [WW+1:0] m_o,
  output logic signed [WW+1:0] m3_o
);
  always_comb begin
    m_o  = {{2{err_i[WW-1]}}, err_i};
    m3_o = m_o + (m_o <<< 1);
  end
endmodule

// File: rtl/dlms_digit_mul.sv
module dlms_digit_mul
  import dlms_wupd_pkg::*;
#(
  parameter int WW = 12,
  parameter int XW = 8,
  localparam int ND  = XW / 2,
  localparam int NLO = ND / 2,
  localparam int PW  = WW + XW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [XW-1:0]        x_i,
  input  logic signed [WW+1:0] m_i,
  input  logic signed [WW+1:0] m3_i,
  output logic signed [PW-1:0] lo_o,
  output logic signed [PW-1:0] hi_o
);
  logic signed [PW-1:0] lo_d, hi_d;

  always_comb begin
    lo_d = '0;
    hi_d = '0;
    for (int j = 0; j < ND; j++) begin
      logic signed [WW+1:0] pp;
      logic signed [PW-1:0] ppx;
      unique case (digit_e'(x_i[2*j +: 2]))
        DIG_ZERO:  pp = '0;
        DIG_ONE:   pp = m_i;
        DIG_TWO:   pp = (j == ND-1) ? -(m_i <<< 1) : (m_i <<< 1);
        default:   pp = (j == ND-1) ? -m_i : m3_i;
      endcase
      ppx = {{(PW-WW-2){pp[WW+1]}}, pp};
      if (j < NLO) lo_d = lo_d + (ppx <<< (2*j));
      else         hi_d = hi_d + (ppx <<< (2*(j-NLO)));
    end
  end

  // mid-tree register: weight-path delay of one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= '0;
      hi_o <= '0;
    end else begin
      lo_o <= lo_d;
      hi_o <= hi_d;
    end
  end
endmodule

// File: rtl/dlms_wacc.sv
module dlms_wacc #(
  parameter int WW = 12,
  parameter int XW = 8,
  parameter int XI = 2,
  localparam int ND   = XW / 2,
  localparam int NLO  = ND / 2,
  localparam int PW   = WW + XW,
  localparam int DROP = XW - XI
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic signed [PW-1:0] lo_i,
  input  logic signed [PW-1:0] hi_i,
  output logic [WW-1:0]        w_o,
  output logic                 ovf_o
);
  logic signed [PW-1:0] prod;
  logic [WW-1:0]        inc, sum;
  logic                 ovf_d;

  always_comb begin
    prod  = lo_i + (hi_i <<< (2*NLO));
    inc   = prod[DROP +: WW];
    sum   = w_o + inc;
    ovf_d = (w_o[WW-1] == inc[WW-1]) && (sum[WW-1] != w_o[WW-1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_o   <= '0;
      ovf_o <= 1'b0;
    end else if (upd_i) begin
      w_o   <= sum;
      ovf_o <= ovf_d;
    end
  end
endmodule

// File: rtl/dlms_wupd.sv
module dlms_wupd #(
  parameter int NTAPS = 4,
  parameter int XW    = 8,
  parameter int XI    = 2,
  parameter int WW    = 12,
  localparam int PW   = WW + XW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [WW-1:0]         err_i,
  input  logic [NTAPS*XW-1:0]   taps_i,
  output logic [NTAPS*WW-1:0]   weights_o,
  output logic [NTAPS-1:0]      ovf_o
);
  logic                 v0_q, v1_q;
  logic [WW-1:0]        err_q;
  logic [NTAPS*XW-1:0]  taps_q;
  logic signed [WW+1:0] m, m3;

  // register ahead of the digit stage (part of error-path latency)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v0_q   <= 1'b0;
      v1_q   <= 1'b0;
      err_q  <= '0;
      taps_q <= '0;
    end else begin
      v0_q   <= valid_i;
      v1_q   <= v0_q;
      err_q  <= err_i;
      taps_q <= taps_i;
    end
  end

  dlms_step_scale #(.WW(WW)) u_scale (
    .err_i (err_q),
    .m_o   (m),
    .m3_o  (m3)
  );

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    logic signed [PW-1:0] lo, hi;

    dlms_digit_mul #(.WW(WW), .XW(XW)) u_mul (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .x_i    (taps_q[t*XW +: XW]),
      .m_i    (m),
      .m3_i   (m3),
      .lo_o   (lo),
      .hi_o   (hi)
    );

    dlms_wacc #(.WW(WW), .XW(XW), .XI(XI)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (v1_q),
      .lo_i   (lo),
      .hi_i   (hi),
      .w_o    (weights_o[t*WW +: WW]),
      .ovf_o  (ovf_o[t])
    );
  end
endmodule

// File: rtl/dlms_wupd_chk.sv
module dlms_wupd_chk #(
  parameter int NTAPS = 4,
  parameter int WW    = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [NTAPS*WW-1:0]  weights_o,
  input logic [NTAPS-1:0]     ovf_o
);
  logic vd1, vd2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vd1 <= 1'b0;
      vd2 <= 1'b0;
    end else begin
      vd1 <= valid_i;
      vd2 <= vd1;
    end
  end

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (weights_o == '0 && ovf_o == '0));

  a_r4_weights_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vd2 |=> $stable(weights_o));

  a_r7_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vd2 |=> $stable(ovf_o));

  a_r3_no_unknown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({weights_o, ovf_o}));

  for (genvar t = 0; t < NTAPS; t++) begin : g_t
    a_r7_ovf_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vd2 |=> (!ovf_o[t] || (weights_o[t*WW+WW-1] != $past(weights_o[t*WW+WW-1]))));
  end
endmodule

bind dlms_wupd dlms_wupd_chk #(.NTAPS(NTAPS), .WW(WW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .weights_o (weights_o),
  .ovf_o     (ovf_o)
);

// File: tb/sim_dlms_wupd.sv
module sim_dlms_wupd;
  localparam int PERIOD = 10;
  localparam int NT = 4, XW = 8, XI = 2, WW = 12;
  localparam int DROP = XW - XI;
  localparam int WMAX = (1 << (WW-1)) - 1;
  localparam int WMIN = -(1 << (WW-1));

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0;
  logic [WW-1:0] err = '0;
  logic [NT*XW-1:0] taps = '0;
  logic [NT*WW-1:0] weights;
  logic [NT-1:0] ovf;

  int checks = 0, errors = 0, ovf_seen = 0;
  string req_tag = "R1";

  always #(PERIOD/2) clk = ~clk;

  dlms_wupd #(.NTAPS(NT), .XW(XW), .XI(XI), .WW(WW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .err_i(err),
    .taps_i(taps), .weights_o(weights), .ovf_o(ovf)
  );

  // behavioural reference: two-slot queue of accepted sets, then accumulate
  int ref_w [NT];
  bit ref_o [NT];
  bit pv [2];
  int pe [2];
  int px [2][NT];

  initial begin
    for (int t = 0; t < NT; t++) begin ref_w[t] = 0; ref_o[t] = 0; end
    for (int s = 0; s < 2; s++) begin
      pv[s] = 0; pe[s] = 0;
      for (int t = 0; t < NT; t++) px[s][t] = 0;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin ref_w[t] = 0; ref_o[t] = 0; end
      pv[0] = 0; pv[1] = 0;
    end else begin
      if (pv[1]) begin
        for (int t = 0; t < NT; t++) begin
          longint p, q;
          logic [WW-1:0] iw, tw;
          int tot;
          p   = longint'(pe[1]) * longint'(px[1][t]);
          q   = p >>> DROP;
          iw  = q[WW-1:0];
          tot = ref_w[t] + int'($signed(iw));
          ref_o[t] = (tot > WMAX) || (tot < WMIN);
          if (ref_o[t]) ovf_seen++;
          tw = tot[WW-1:0];
          ref_w[t] = int'($signed(tw));
        end
      end
      pv[1] = pv[0]; pe[1] = pe[0];
      for (int t = 0; t < NT; t++) px[1][t] = px[0][t];
      pv[0] = valid; pe[0] = int'($signed(err));
      for (int t = 0; t < NT; t++) px[0][t] = int'($signed(taps[t*XW +: XW]));
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    for (int t = 0; t < NT; t++) begin
      checks++;
      if (int'($signed(weights[t*WW +: WW])) != ref_w[t]) begin
        errors++;
        $display("FAIL %s tap %0d weight act %0d exp %0d", req_tag, t,
                 $signed(weights[t*WW +: WW]), ref_w[t]);
      end
      checks++;
      if (ovf[t] !== ref_o[t]) begin
        errors++;
        $display("FAIL %s tap %0d ovf act %0b exp %0b", req_tag, t, ovf[t], ref_o[t]);
      end
    end
  end

  task automatic drive(input bit v, input int e, input int x0, input int x1,
                       input int x2, input int x3);
    @(negedge clk);
    valid = v;
    err = WW'(e);
    taps = {XW'(x3), XW'(x2), XW'(x1), XW'(x0)};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(PERIOD*100000);
    errors++;
    $display("FAIL watchdog expired act running exp finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    req_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    req_tag = "R3";          // single pulse, weights move on third edge only
    drive(1, 500, 3, 0, 0, 0);
    idle(5);

    req_tag = "R9";          // distinct samples per tap
    drive(1, 300, 10, -20, 40, -64);
    idle(4);

    req_tag = "R2";
    drive(1, 1000, 1, 2, 3, 5);
    drive(0, 0, 0, 0, 0, 0);
    drive(1, -777, 7, 13, -7, 33);
    idle(4);

    req_tag = "R8";          // negative products floor
    drive(1, -1, 1, -1, 1, 1);
    idle(3);
    drive(1, 1, -1, -3, -65, 63);
    idle(4);

    req_tag = "R6";          // extreme samples, signed top digit
    drive(1, 2047, -128, 127, -128, 127);
    idle(3);
    drive(1, -2048, -128, 127, 64, -65);
    idle(4);

    req_tag = "R4";          // noisy inputs while not valid
    for (int i = 0; i < 8; i++)
      drive(0, int'($urandom_range(0, 4095)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)));
    idle(2);

    req_tag = "R5";          // back-to-back accumulation
    for (int i = 0; i < 6; i++) drive(1, 100 + 37*i, 5, -9, 17, 33 - i);
    idle(4);

    req_tag = "R7";          // wrap and flag, then clear
    for (int i = 0; i < 4; i++) drive(1, 2047, 64, 64, -64, 64);
    drive(0, 2047, 64, 64, 64, 64);
    idle(3);
    drive(1, 0, 0, 0, 0, 0);
    idle(4);
    checks++;
    if (ovf_seen == 0) begin
      errors++;
      $display("FAIL R7 overflow events act %0d exp >0", ovf_seen);
    end

    req_tag = "R2";          // mixed random traffic
    for (int i = 0; i < 200; i++)
      drive(($urandom_range(0, 2) != 0), int'($urandom_range(0, 4095)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    idle(4);

    req_tag = "R1";          // reset mid-run clears state
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule